// File: doc/BRIEF.md
# Lane-Wise Widening Shift-Left Vector Unit

This unit runs one family of vector instructions. For each 128-bit lane of a source vector it takes the elements in the lower 64 bits of that lane. It widens each of them to twice its width, by sign or zero extension, and shifts the widened value left by a small immediate. The results fill the whole destination lane. The element pairs are byte to halfword, halfword to word and word to doubleword. A separate form extends the low 64-bit element of each lane to a full 128-bit value, with no shift.

The unit decodes the 32-bit instruction word itself. It returns the source register index at once, so that a register file can supply the operand in the same cycle. Operations are accepted through a valid/ready handshake. The result comes back from an output register exactly one cycle later. An input selects the operation length: one lane (128 bits) or two lanes (256 bits). Each length has its own enable input. A word that is not a legal encoding, or a length that is not enabled, gives a one-cycle fault instead of a result.

Top module: `vwiden_unit`

## Requirements
- R1: A word is legal only if bits [31:20] equal 0111_0111_0000, bit 19 is 1, bit 17 is 0 and bits [16:15] are not 11. Groups with bits [16:15]=00 also need bit 14 or bit 13 set. Groups with bits [16:15]=10 need bits [14:10] to be zero. An accepted word that breaks these rules raises outFault and not outValid.
- R2: With bits [16:15]=00 and bits [14:13]=01 (byte form), destination halfword j of lane i comes from source byte j of lane i, for j = 0..7. Only the low 64 bits of each lane are read.
- R3: Bit 18 chooses the extension: 0 extends the sign, 1 fills with zeros. This holds for every element size and for the quad form.
- R4: The shift amount is bits [12:10] for the byte form (bits [14:13]=01), bits [13:10] for the halfword form (bit 14=1), and bits [14:10] for the word form (bits [16:15]=01). The shift is applied after extension, modulo the destination element width.
- R5: With bits [16:15]=10 (quad form), each lane receives its low 64-bit source element, extended to 128 bits.
- R6: When lenWide=1 both lanes are computed. When lenWide=0 only lane 0 is computed and outData[255:128] is zero.
- R7: If the enable for the requested length is low (enWide for lenWide=1, enNarrow for lenWide=0), an accepted word raises outFault and no result.
- R8: An operation accepted at a clock edge shows on outValid or outFault at the next edge. While an output is held and outReady is low, inReady is low and every output keeps its value.
- R9: outDst carries bits [4:0] of the accepted word. srcIdx shows bits [9:5] of instrWord combinationally.
- R10: outValid and outFault are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation offered |
| inReady | output | 1 | Unit can take an operation |
| instrWord | input | 32 | Instruction word |
| lenWide | input | 1 | 1 = two lanes, 0 = one lane |
| enNarrow | input | 1 | Enable for one-lane operations |
| enWide | input | 1 | Enable for two-lane operations |
| srcIdx | output | 5 | Source register index, decoded combinationally |
| srcData | input | 256 | Source vector operand |
| outReady | input | 1 | Consumer takes the held output |
| outValid | output | 1 | Result held in outData |
| outFault | output | 1 | Illegal word or disabled length |
| outDst | output | 5 | Destination register index of the result |
| outData | output | 256 | Result vector |

## Verification
Some properties are checked by assertions on every cycle. Valid and fault are never high together. Every acceptance produces a response at the next edge. A held output stays stable under backpressure. A one-lane result has a zero upper half, and an unsigned quad result has a zero upper lane half. The bench alone shows that the arithmetic is right. It sweeps every element size, both extension kinds, every immediate value and both lengths, and compares each result with values it computes itself. The bench alone also shows the illegal-encoding and disabled-length cases, and the exact index routing.

// File: rtl/vwiden_pkg.sv
package vwiden_pkg;
  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2,
    SZ_Q = 2'd3
  } elemSize_e;

  typedef struct packed {
    logic      legal;
    elemSize_e size;
    logic      zeroExt;
    logic [5:0] shamt;
    logic [4:0] dstIdx;
    logic [4:0] srcIdx;
  } decOp_t;

  typedef struct packed {
    logic capture;
    logic fault;
    logic drain;
  } ctrlStrobe_t;
endpackage

// File: rtl/vwiden_decode.sv
module vwiden_decode
  import vwiden_pkg::*;
#(
  parameter logic [11:0] PREFIX = 12'b0111_0111_0000
) (
  input  logic [31:0] instrWord,
  output decOp_t      op
);
  logic [4:0] grp;
  logic [4:0] slot;

  always_comb begin
    grp  = instrWord[19:15];
    slot = instrWord[14:10];
    op.legal   = 1'b0;
    op.size    = SZ_B;
    op.zeroExt = grp[3];
    op.shamt   = '0;
    op.dstIdx  = instrWord[4:0];
    op.srcIdx  = instrWord[9:5];
    if (instrWord[31:20] == PREFIX && grp[4] && !grp[2]) begin
      unique case (grp[1:0])
        2'b00: begin
          if (slot[4]) begin
            op.legal = 1'b1;
            op.size  = SZ_H;
            op.shamt = {2'b00, slot[3:0]};
          end else if (slot[3]) begin
            op.legal = 1'b1;
            op.size  = SZ_B;
            op.shamt = {3'b000, slot[2:0]};
          end
        end
        2'b01: begin
          op.legal = 1'b1;
          op.size  = SZ_W;
          op.shamt = {1'b0, slot};
        end
        2'b10: begin
          op.legal = (slot == 5'd0);
          op.size  = SZ_Q;
        end
        default: op.legal = 1'b0;
      endcase
    end
  end

  // R4
  always_comb begin
    if (op.legal && op.size == SZ_B) shamt_range_chk: assert (op.shamt < 6'd8);
  end
endmodule

// File: rtl/vwiden_ctrl.sv
module vwiden_ctrl
  import vwiden_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        outReady,
  input  logic        opLegal,
  input  logic        lenWide,
  input  logic        enNarrow,
  input  logic        enWide,
  output logic        inReady,
  output ctrlStrobe_t strobe,
  output logic        outValid,
  output logic        outFault
);
  logic busy;
  logic accept;
  logic lenOk;

  always_comb begin
    busy           = outValid | outFault;
    inReady        = !busy || outReady;
    accept         = inValid && inReady;
    lenOk          = lenWide ? enWide : enNarrow;
    strobe.capture = accept && opLegal && lenOk;
    strobe.fault   = accept && !(opLegal && lenOk);
    strobe.drain   = busy && outReady && !accept;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outFault <= 1'b0;
    end else if (strobe.capture) begin
      outValid <= 1'b1;
      outFault <= 1'b0;
    end else if (strobe.fault) begin
      outValid <= 1'b0;
      outFault <= 1'b1;
    end else if (strobe.drain) begin
      outValid <= 1'b0;
      outFault <= 1'b0;
    end
  end

  // R10
  excl_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(outValid && outFault));

  // R8
  one_cycle_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> (outValid || outFault));

  // R8
  hold_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((outValid || outFault) && !outReady) |=> ($stable(outValid) && $stable(outFault)));
endmodule

// File: rtl/vwiden_datapath.sv
module vwiden_datapath
  import vwiden_pkg::*;
#(
  parameter int LANE_W = 128,
  parameter int LANES  = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobe_t                strobe,
  input  decOp_t                     op,
  input  logic                       lenWide,
  input  logic [LANE_W*LANES-1:0]    srcData,
  output logic [LANE_W*LANES-1:0]    outData,
  output logic [4:0]                 outDst
);
  localparam int DATA_W = LANE_W * LANES;
  localparam int HALF_W = LANE_W / 2;
  localparam int NB     = HALF_W / 8;
  localparam int NH     = HALF_W / 16;
  localparam int NW     = HALF_W / 32;

  logic [DATA_W-1:0] nextData;

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic [HALF_W-1:0] lo;
    logic [LANE_W-1:0] laneRes;
    logic              laneOn;

    always_comb begin
      logic [15:0] e16;
      logic [31:0] e32;
      logic [63:0] e64;
      lo      = srcData[ln*LANE_W +: HALF_W];
      laneOn  = (ln == 0) || lenWide;
      laneRes = '0;
      e16 = '0;
      e32 = '0;
      e64 = '0;
      unique case (op.size)
        SZ_B: for (int j = 0; j < NB; j++) begin
          e16 = {{8{!op.zeroExt && lo[8*j+7]}}, lo[8*j +: 8]};
          laneRes[16*j +: 16] = e16 << op.shamt[3:0];
        end
        SZ_H: for (int j = 0; j < NH; j++) begin
          e32 = {{16{!op.zeroExt && lo[16*j+15]}}, lo[16*j +: 16]};
          laneRes[32*j +: 32] = e32 << op.shamt[4:0];
        end
        SZ_W: for (int j = 0; j < NW; j++) begin
          e64 = {{32{!op.zeroExt && lo[32*j+31]}}, lo[32*j +: 32]};
          laneRes[64*j +: 64] = e64 << op.shamt[5:0];
        end
        default: laneRes = {{HALF_W{!op.zeroExt && lo[HALF_W-1]}}, lo};
      endcase
      nextData[ln*LANE_W +: LANE_W] = laneOn ? laneRes : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outData <= '0;
      outDst  <= '0;
    end else if (strobe.capture) begin
      outData <= nextData;
      outDst  <= op.dstIdx;
    end
  end

  // R6
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !lenWide) |=> (outData[DATA_W-1:LANE_W] == '0));

  // R5
  quad_zero_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && op.size == SZ_Q && op.zeroExt) |=> (outData[LANE_W-1:HALF_W] == '0));

  // R8
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> ($stable(outData) && $stable(outDst)));
endmodule

// File: rtl/vwiden_unit.sv
module vwiden_unit
  import vwiden_pkg::*;
#(
  parameter int LANE_W = 128,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  output logic                    inReady,
  input  logic [31:0]             instrWord,
  input  logic                    lenWide,
  input  logic                    enNarrow,
  input  logic                    enWide,
  output logic [4:0]              srcIdx,
  input  logic [LANE_W*LANES-1:0] srcData,
  input  logic                    outReady,
  output logic                    outValid,
  output logic                    outFault,
  output logic [4:0]              outDst,
  output logic [LANE_W*LANES-1:0] outData
);
  decOp_t      op;
  ctrlStrobe_t strobe;

  vwiden_decode u_dec (
    .instrWord (instrWord),
    .op        (op)
  );

  assign srcIdx = op.srcIdx;

  vwiden_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .outReady (outReady),
    .opLegal  (op.legal),
    .lenWide  (lenWide),
    .enNarrow (enNarrow),
    .enWide   (enWide),
    .inReady  (inReady),
    .strobe   (strobe),
    .outValid (outValid),
    .outFault (outFault)
  );

  vwiden_datapath #(.LANE_W(LANE_W), .LANES(LANES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .op       (op),
    .lenWide  (lenWide),
    .srcData  (srcData),
    .outData  (outData),
    .outDst   (outDst)
  );
endmodule

// File: tb/sim_vwiden_unit.sv
module sim_vwiden_unit;
  logic         clk = 0;
  logic         rstN = 0;
  logic         inValid = 0;
  logic         inReady;
  logic [31:0]  instrWord = '0;
  logic         lenWide = 0;
  logic         enNarrow = 1;
  logic         enWide = 1;
  logic [4:0]   srcIdx;
  logic [255:0] srcData = '0;
  logic         outReady = 1;
  logic         outValid;
  logic         outFault;
  logic [4:0]   outDst;
  logic [255:0] outData;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  vwiden_unit u0 (.*);

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkWord(input int sz, input bit uns, input int imm,
                                         input logic [4:0] vj, input logic [4:0] vd);
    logic [4:0] grp;
    logic [4:0] slot;
    grp = {1'b1, uns, 3'b000};
    case (sz)
      0: slot = {2'b01, 3'(imm)};
      1: slot = {1'b1, 4'(imm)};
      2: begin grp[1:0] = 2'b01; slot = 5'(imm); end
      default: begin grp[1:0] = 2'b10; slot = 5'd0; end
    endcase
    return {12'b0111_0111_0000, grp, slot, vj, vd};
  endfunction

  function automatic logic [255:0] model(input int sz, input bit uns, input int imm,
                                         input bit wide, input logic [255:0] s);
    logic [255:0] r = '0;
    for (int ln = 0; ln < 2; ln++) begin
      if (ln == 1 && !wide) continue;
      case (sz)
        0: for (int j = 0; j < 8; j++) begin
          logic [15:0] e;
          e = uns ? 16'(s[ln*128+8*j +: 8]) : 16'($signed(s[ln*128+8*j +: 8]));
          r[ln*128+16*j +: 16] = e << (imm % 16);
        end
        1: for (int j = 0; j < 4; j++) begin
          logic [31:0] e;
          e = uns ? 32'(s[ln*128+16*j +: 16]) : 32'($signed(s[ln*128+16*j +: 16]));
          r[ln*128+32*j +: 32] = e << (imm % 32);
        end
        2: for (int j = 0; j < 2; j++) begin
          logic [63:0] e;
          e = uns ? 64'(s[ln*128+32*j +: 32]) : 64'($signed(s[ln*128+32*j +: 32]));
          r[ln*128+64*j +: 64] = e << (imm % 64);
        end
        default: r[ln*128 +: 128] = uns ? 128'(s[ln*128 +: 64]) : 128'($signed(s[ln*128 +: 64]));
      endcase
    end
    return r;
  endfunction

  // issue one word, sample one cycle later at the falling edge
  task automatic issue(input logic [31:0] w, input bit wide, input logic [255:0] s);
    @(negedge clk);
    instrWord = w;
    lenWide   = wide;
    srcData   = s;
    inValid   = 1;
    @(negedge clk);
    inValid   = 0;
  endtask

  task automatic expectFault(input string tag, input logic [31:0] w, input bit wide);
    issue(w, wide, 256'h1234);
    chk({tag, " fault"}, outFault, 1);
    chk({tag, " no result"}, outValid, 0);
  endtask

  initial begin
    logic [255:0] pats [3];
    logic [255:0] held;
    int maxImm;
    pats[0] = {4{64'h80FF_7F01_8000_7FFF}};
    pats[1] = {64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_8765_4321,
               64'hA5A5_5A5A_C3C3_3C3C, 64'h8000_0001_7FFF_FFFF};
    pats[2] = {64'hDEAD_BEEF_0000_0000, 64'hF0F0_0F0F_8181_7E7E,
               64'h1111_2222_3333_4444, 64'h9999_AAAA_BBBB_CCCC};

    repeat (3) @(negedge clk);
    // reset state
    chk("R8 reset valid", outValid, 0);
    chk("R10 reset fault", outFault, 0);
    chk("R8 reset inReady", inReady, 1);
    rstN = 1;

    // R9 combinational source index
    @(negedge clk);
    instrWord = mkWord(0, 0, 0, 5'd19, 5'd6);
    #1 chk("R9 srcIdx", srcIdx, 19);

    // R2 R3 R4 R5 R6 sweep
    for (int p = 0; p < 3; p++)
      for (int wide = 0; wide < 2; wide++)
        for (int uns = 0; uns < 2; uns++)
          for (int sz = 0; sz < 4; sz++) begin
            maxImm = (sz == 0) ? 8 : (sz == 1) ? 16 : (sz == 2) ? 32 : 1;
            for (int imm = 0; imm < maxImm; imm++) begin
              logic [4:0] vd;
              vd = 5'(imm + sz);
              issue(mkWord(sz, bit'(uns), imm, 5'd3, vd), bit'(wide), pats[p]);
              chk("R2 R3 R4 R5 R6 data", outData, model(sz, bit'(uns), imm, bit'(wide), pats[p]));
              chk("R8 valid", outValid, 1);
              chk("R10 no fault", outFault, 0);
              chk("R9 dst", outDst, vd);
            end
          end

    // R1 illegal encodings
    expectFault("R1 bad prefix", mkWord(0, 0, 1, 1, 1) ^ 32'h8000_0000, 1);
    expectFault("R1 group 11", {12'b0111_0111_0000, 5'b10011, 5'd0, 10'd0}, 0);
    expectFault("R1 bit17 set", {12'b0111_0111_0000, 5'b10100, 5'b01000, 10'd0}, 0);
    expectFault("R1 slot 00", {12'b0111_0111_0000, 5'b11000, 5'b00111, 10'd0}, 1);
    expectFault("R1 quad slot", {12'b0111_0111_0000, 5'b10010, 5'b00001, 10'd0}, 0);
    expectFault("R1 bit19 clear", {12'b0111_0111_0000, 5'b00001, 5'd0, 10'd0}, 0);

    // R7 disabled lengths
    enWide = 0;
    expectFault("R7 wide off", mkWord(1, 0, 2, 1, 1), 1);
    issue(mkWord(1, 0, 2, 1, 4), 0, pats[1]);
    chk("R7 narrow still on", outValid, 1);
    chk("R7 narrow data", outData, model(1, 0, 2, 0, pats[1]));
    enWide = 1;
    enNarrow = 0;
    expectFault("R7 narrow off", mkWord(2, 1, 3, 1, 1), 0);
    enNarrow = 1;
    @(negedge clk);
    chk("R8 fault one cycle", outFault, 0);

    // R8 backpressure
    issue(mkWord(0, 1, 5, 2, 5'd21), 1, pats[2]);
    held = model(0, 1, 5, 1, pats[2]);
    outReady = 0;
    instrWord = mkWord(3, 0, 0, 2, 5'd9);
    srcData = pats[0];
    inValid = 1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R8 stall inReady", inReady, 0);
      chk("R8 stall data", outData, held);
      chk("R8 stall dst", outDst, 21);
    end
    outReady = 1;
    @(negedge clk);
    inValid = 0;
    chk("R8 after stall data", outData, model(3, 0, 0, 1, pats[0]));
    chk("R8 after stall dst", outDst, 9);
    @(negedge clk);
    chk("R8 drained", outValid, 0);

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule